// File: doc/BRIEF.md
# Page-Buffered Self-Timed Write Engine

This block sits behind the byte receiver of a two-wire serial memory slave. Data bytes from one write transaction are held in an eight-entry page buffer, and a per-entry valid mask records which offsets were filled. The byte receiver sends it strobes for the events it decodes: a word address arriving, a data byte arriving, the STOP that ends a write, and a repeated START that cancels one. Nothing reaches the memory array before the commit strobe. The commit starts a write cycle that runs for a fixed, parameterized number of system clocks. During that cycle the engine sweeps the buffer and issues one array write for each marked offset.

The write pointer moves only in its low offset bits. Bytes past the end of a page therefore wrap to its start and replace what was buffered there. The page number stays fixed for the whole transaction. A byte write is the same flow with a single buffered byte. While the cycle runs, the busy flag is high. The byte receiver uses that flag to withhold its acknowledge, and the engine ignores every strobe. The pointer output tells the receiver's address counter where the last access ended.

Top module: `pgwr_engine`

## Requirements
- R1: After reset, busy_o is low, mem_we_o is low and last_addr_o is zero.
- R2: An accepted load sets last_addr_o to addr_i on the next cycle and discards any bytes already buffered. A load that arrives together with a data strobe wins, and the data byte is dropped.
- R3: Each accepted data byte is stored at the offset given by last_addr_o[2:0]. After it, the low three bits of the pointer increment modulo 8 and bits [7:3] do not change.
- R4: When more than eight bytes arrive before a commit, a later byte replaces the earlier byte at the same offset. The array receives the newest value for each offset.
- R5: No array write occurs before a commit. A commit with at least one buffered byte raises busy_o on the next cycle, and busy_o stays high for exactly WR_CYCLES cycles.
- R6: In the first eight cycles of a write cycle, the write port visits offsets 0 to 7 in ascending order. It asserts mem_we_o only for marked offsets, at address {last_addr_o[7:3], offset}. Array locations at unmarked offsets are not written.
- R7: A commit while the buffer is empty starts no write cycle.
- R8: An abort clears the buffer without a write cycle and keeps last_addr_o. It takes priority over a commit, load or data strobe in the same cycle. Overall priority is abort, then commit, then load, then data.
- R9: While busy_o is high, the load, data, commit and abort strobes have no effect, and last_addr_o does not change.
- R10: After a write cycle the buffer is empty, so a second commit with no new data does nothing. last_addr_o holds the final incremented in-page address.
- R11: A single buffered byte produces exactly one array write, with its data at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Word address strobe |
| addr_i | input | ADDR_W | Word address |
| data_vld_i | input | 1 | Data byte strobe |
| data_i | input | DATA_W | Data byte |
| commit_i | input | 1 | STOP seen, start the write cycle |
| abort_i | input | 1 | Repeated START, drop the buffer |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Write cycle in progress |
| last_addr_o | output | ADDR_W | Current write pointer |

## Verification
The bench fills a page starting at offset 5, so the pointer wraps from 7 to 0 inside the page. A design that carried into the page bits would write into the next page. Ten bytes into one page check that the newest byte at each offset reaches the array. A design that appended instead would write stale data, or more than eight entries. Three further cases check that nothing reaches the array: a commit on an empty buffer, an abort racing a commit, and strobes sent during the busy window. A design that got any of these wrong would issue spurious writes, move the pointer, or stretch busy_o. The bench also times busy_o to the exact cycle.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  // strobes that survive the busy gate and the priority order
  typedef struct packed {
    logic load;
    logic data;
    logic commit;
    logic abort;
  } pgwr_cmd_t;
endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DEPTH-1:0]  valid_o
);

  logic [DATA_W-1:0] ent_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              hit;
    logic [DATA_W-1:0] ent_q;
    logic              vld_q;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    // payload: enable only, no reset needed
    always_ff @(posedge clk) begin
      if (hit) ent_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q <= 1'b0;
      else if (clr) vld_q <= 1'b0;
      else if (hit) vld_q <= 1'b1;
    end

    assign ent_arr[g] = ent_q;
    assign valid_o[g] = vld_q;
  end

  assign rd_data = ent_arr[rd_idx];

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int CYCLES = 40,
  localparam int CNT_W = $clog2(CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign done_o = busy_q && (cnt_q == LAST);

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 40,   // must exceed PAGE_BYTES
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(WR_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] last_addr_o
);

  pgwr_cmd_t               acc;
  logic [ADDR_W-1:0]       ptr_q, ptr_d;
  logic                    ptr_en;
  logic [PAGE_BYTES-1:0]   buf_valid;
  logic [DATA_W-1:0]       rd_data;
  logic [CNT_W-1:0]        cyc_cnt;
  logic                    busy, done;
  logic [OFF_W-1:0]        sweep_idx;
  logic                    in_sweep;

  // strobe gating and priority: abort > commit > load > data
  always_comb begin
    acc = '0;
    if (!busy) begin
      if (abort_i)         acc.abort  = 1'b1;
      else if (commit_i)   acc.commit = |buf_valid;
      else if (load_i)     acc.load   = 1'b1;
      else if (data_vld_i) acc.data   = 1'b1;
    end
  end

  // write pointer: page bits move only on load
  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = acc.load | acc.data;
    if (acc.load)
      ptr_d = addr_i;
    else if (acc.data)
      ptr_d = {ptr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0] + OFF_W'(1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  pgwr_buffer #(
    .DATA_W (DATA_W),
    .DEPTH  (PAGE_BYTES)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc.data),
    .wr_idx  (ptr_q[OFF_W-1:0]),
    .wr_data (data_i),
    .clr     (acc.load | acc.abort | done),
    .rd_idx  (sweep_idx),
    .rd_data (rd_data),
    .valid_o (buf_valid)
  );

  pgwr_timer #(
    .CYCLES (WR_CYCLES)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (acc.commit),
    .busy_o (busy),
    .cnt_o  (cyc_cnt),
    .done_o (done)
  );

  // sweep: the first PAGE_BYTES cycles of the write cycle walk the offsets
  assign sweep_idx = cyc_cnt[OFF_W-1:0];
  assign in_sweep  = cyc_cnt < CNT_W'(PAGE_BYTES);

  assign mem_we_o    = busy && in_sweep && buf_valid[sweep_idx];
  assign mem_addr_o  = {ptr_q[ADDR_W-1:OFF_W], sweep_idx};
  assign mem_wdata_o = rd_data;
  assign busy_o      = busy;
  assign last_addr_o = ptr_q;

endmodule

// File: rtl/pgwr_engine_chk.sv
module pgwr_engine_chk #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 40,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              data_vld_i,
  input logic              commit_i,
  input logic              abort_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] last_addr_o,
  input logic [PAGE_BYTES-1:0] valid
);

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 32'd1;
    else             run_q <= '0;
  end

  p_write_in_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_q == 32'(WR_CYCLES));

  p_busy_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> run_q < 32'(WR_CYCLES));

  p_commit_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !abort_i && !busy_o && (valid != '0)) |=> busy_o);

  p_empty_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !busy_o && (valid == '0)) |=> !busy_o);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !busy_o) |=> (!busy_o && (valid == '0) && $stable(last_addr_o)));

  p_load_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !abort_i && !commit_i && !busy_o)
      |=> (last_addr_o == $past(addr_i)) && (valid == '0));

  p_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_vld_i && !load_i && !abort_i && !commit_i && !busy_o)
      |=> ($stable(last_addr_o[ADDR_W-1:OFF_W]) &&
           (last_addr_o[OFF_W-1:0] ==
            OFF_W'($past(last_addr_o[OFF_W-1:0]) + OFF_W'(1)))));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(last_addr_o));

  p_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:OFF_W] == last_addr_o[ADDR_W-1:OFF_W]));

  p_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (valid == '0));

endmodule

bind pgwr_engine pgwr_engine_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .WR_CYCLES  (WR_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .addr_i      (addr_i),
  .data_vld_i  (data_vld_i),
  .commit_i    (commit_i),
  .abort_i     (abort_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .busy_o      (busy_o),
  .last_addr_o (last_addr_o),
  .valid       (buf_valid)
);

// File: tb/pgwr_engine_bench.sv
`timescale 1ns/1ps
module pgwr_engine_bench;

  localparam int WR = 40;

  logic       clk;
  logic       rst_n;
  logic       load_i, data_vld_i, commit_i, abort_i;
  logic [7:0] addr_i, data_i;
  logic       mem_we_o, busy_o;
  logic [7:0] mem_addr_o, mem_wdata_o, last_addr_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [7:0] mem_val [256];
  bit         mem_hit [256];
  logic [7:0] wr_log  [16];
  int         wr_cnt;

  pgwr_engine #(.WR_CYCLES(WR)) u_pgwr_engine (
    .clk (clk), .rst_n (rst_n),
    .load_i (load_i), .addr_i (addr_i),
    .data_vld_i (data_vld_i), .data_i (data_i),
    .commit_i (commit_i), .abort_i (abort_i),
    .mem_we_o (mem_we_o), .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o),
    .busy_o (busy_o), .last_addr_o (last_addr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // array model: records the write port between edges
  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      mem_val[mem_addr_o] = mem_wdata_o;
      mem_hit[mem_addr_o] = 1'b1;
      if (wr_cnt < 16) wr_log[wr_cnt] = mem_addr_o;
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_cnt = 0;
    for (int i = 0; i < 256; i++) mem_hit[i] = 1'b0;
  endtask

  task automatic pulse(input bit ld, input bit dv, input bit cm, input bit ab,
                       input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    load_i = ld; data_vld_i = dv; commit_i = cm; abort_i = ab;
    addr_i = a; data_i = d;
    @(negedge clk);
    load_i = 0; data_vld_i = 0; commit_i = 0; abort_i = 0;
  endtask

  task automatic do_load(input logic [7:0] a);   pulse(1, 0, 0, 0, a, 8'h00); endtask
  task automatic do_data(input logic [7:0] d);   pulse(0, 1, 0, 0, 8'h00, d); endtask
  task automatic do_commit();                    pulse(0, 0, 1, 0, 8'h00, 8'h00); endtask

  // called right after a commit pulse; counts busy cycles
  task automatic wait_cycle(output int n);
    n = 0;
    while (busy_o) begin
      n++;
      @(negedge clk);
    end
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 we", mem_we_o, 0);
    chk("R1 ptr", last_addr_o, 8'h00);
  endtask

  task automatic t_single();
    int n;
    clear_log();
    do_load(8'h25);
    do_data(8'hA5);
    repeat (3) @(negedge clk);
    #1;
    chk("R5 no write before commit", wr_cnt, 0);
    chk("R5 idle before commit", busy_o, 0);
    do_commit();
    chk("R5 busy after commit", busy_o, 1);
    wait_cycle(n);
    chk("R5 busy length", n, WR);
    chk("R11 write count", wr_cnt, 1);
    chk("R11 data", mem_val[8'h25], 8'hA5);
    chk("R10 final pointer", last_addr_o, 8'h26);
  endtask

  task automatic t_wrap();
    int n;
    clear_log();
    do_load(8'h3D);
    do_data(8'h11); do_data(8'h22); do_data(8'h33); do_data(8'h44);
    chk("R3 wrapped pointer", last_addr_o, 8'h39);
    do_commit();
    wait_cycle(n);
    chk("R6 write count", wr_cnt, 4);
    chk("R6 order 0", wr_log[0], 8'h38);
    chk("R6 order 1", wr_log[1], 8'h3D);
    chk("R6 order 2", wr_log[2], 8'h3E);
    chk("R6 order 3", wr_log[3], 8'h3F);
    chk("R6 unmarked untouched", mem_hit[8'h3C], 0);
    chk("R3 no next page", mem_hit[8'h40], 0);
    chk("R3 data at 38", mem_val[8'h38], 8'h44);
    chk("R3 data at 3D", mem_val[8'h3D], 8'h11);
    do_commit();
    chk("R10 second commit idle", busy_o, 0);
    repeat (2) @(negedge clk);
    #1;
    chk("R10 no extra write", wr_cnt, 4);
  endtask

  task automatic t_overflow();
    int n;
    clear_log();
    do_load(8'h80);
    for (int i = 0; i < 10; i++) do_data(8'h60 + 8'(i));
    chk("R4 pointer", last_addr_o, 8'h82);
    do_commit();
    wait_cycle(n);
    chk("R4 write count", wr_cnt, 8);
    chk("R4 offset 0 newest", mem_val[8'h80], 8'h68);
    chk("R4 offset 1 newest", mem_val[8'h81], 8'h69);
    chk("R4 offset 2", mem_val[8'h82], 8'h62);
    chk("R4 offset 7", mem_val[8'h87], 8'h67);
  endtask

  task automatic t_empty();
    clear_log();
    do_load(8'h10);
    do_commit();
    chk("R7 no busy", busy_o, 0);
    repeat (3) @(negedge clk);
    #1;
    chk("R7 still idle", busy_o, 0);
    chk("R7 no write", wr_cnt, 0);
    chk("R7 pointer", last_addr_o, 8'h10);
  endtask

  task automatic t_reload();
    int n;
    clear_log();
    do_load(8'h60);
    do_data(8'h11);
    do_load(8'h70);
    chk("R2 pointer loaded", last_addr_o, 8'h70);
    pulse(1, 1, 0, 0, 8'h70, 8'hEE);   // load beats data
    chk("R2 data dropped", last_addr_o, 8'h70);
    do_data(8'h22);
    do_commit();
    wait_cycle(n);
    chk("R2 write count", wr_cnt, 1);
    chk("R2 old byte gone", mem_hit[8'h60], 0);
    chk("R2 new byte", mem_val[8'h70], 8'h22);
  endtask

  task automatic t_abort();
    clear_log();
    do_load(8'h50);
    do_data(8'h01);
    do_data(8'h02);
    pulse(0, 0, 1, 1, 8'h00, 8'h00);   // abort with commit
    chk("R8 abort beats commit", busy_o, 0);
    chk("R8 pointer kept", last_addr_o, 8'h52);
    do_commit();
    chk("R8 buffer emptied", busy_o, 0);
    repeat (2) @(negedge clk);
    #1;
    chk("R8 no write", wr_cnt, 0);
  endtask

  task automatic t_busy_ignore();
    int n;
    clear_log();
    do_load(8'hC4);
    do_data(8'h5A);
    do_commit();
    do_load(8'h00);
    do_data(8'hFF);
    pulse(0, 0, 0, 1, 8'h00, 8'h00);
    do_commit();
    chk("R9 pointer held", last_addr_o, 8'hC5);
    chk("R9 still busy", busy_o, 1);
    wait_cycle(n);
    chk("R9 write count", wr_cnt, 1);
    chk("R9 data", mem_val[8'hC4], 8'h5A);
    chk("R9 load ignored", mem_hit[8'h00], 0);
    chk("R9 pointer after", last_addr_o, 8'hC5);
    do_commit();
    chk("R9 no retrigger", busy_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    load_i = 0; data_vld_i = 0; commit_i = 0; abort_i = 0;
    addr_i = 0; data_i = 0;
    wr_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      mem_val[i] = 8'h00;
      mem_hit[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_overflow();
    t_empty();
    t_reload();
    t_abort();
    t_busy_ignore();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule